// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a clocked host and an external asynchronous static RAM of 256K words by 16 bits. The host presents one request at a time: an address, a write flag, write data and a two-bit byte-lane select. The controller accepts it while its ready output is high and then walks the memory pins through a fixed sequence. It returns a one-cycle done pulse when the access completes, and for a read the captured data comes back with that pulse.

All memory strobes are active low and come straight from registers, so no decode glitch reaches the memory. A read holds chip enable and output enable low for a programmable number of clocks, samples the data bus on the last of them, releases output enable, and then spends one turnaround cycle fully deselected. A write drives the data bus while output enable stays high for the whole cycle. It lowers write enable for a programmable width and ends the write by raising it, with address and data still held. The address register only loads when a request is accepted, which is always a cycle with write enable high. The data bus is split into an output value, an output-enable and an input value, so the pad ring can build the tri-state buffer.

Timing is set in clock cycles by three parameters. At a 125 MHz clock, an access of 2 cycles, a setup of 1 cycle and a pulse of 1 cycle satisfy the fastest memory grade: 16 ns of access, 8 ns of data setup and an 8 ns write pulse.

Top module: `sram_bytelane_ctrl`

## Requirements
- R1: While rst_n is low, every memory strobe (chip, write, output, upper byte, lower byte enable) is high, the data driver is off, req_ready is low, the address and data outputs are zero, and a request presented during reset is never performed.
- R2: When no request is in progress, req_ready is high, all memory strobes are high (standby) and the data driver is off.
- R3: A read accepted at a clock edge holds chip enable low, output enable low and write enable high for exactly RD_CYCLES cycles, starting in the next cycle. During those cycles the byte strobes are the inverse of the lane select: bit 0 selects the lower byte (lower strobe, data bits 7:0) and bit 1 selects the upper byte (upper strobe, data bits 15:8).
- R4: In the cycle after the last read access cycle, output enable is high, chip enable is still low, rsp_done is high, and rsp_rdata holds the memory data sampled at the end of the access, with the bits of unselected lanes returned as zero.
- R5: A write accepted at a clock edge spends WR_SETUP_CYCLES cycles with chip enable low, write enable high and the data bus driven. It then spends WR_PULSE_CYCLES cycles with write enable low, and then one hold cycle with write enable high, the bus still driven and rsp_done high.
- R6: Output enable is high in every write cycle, and write enable is only ever low while chip enable is low and the bus is driven.
- R7: sram_addr changes only at acceptance of a request, to the request address, and only between cycles in which write enable is high. Address and driven write data do not change while write enable stays low.
- R8: A write changes only the memory byte lanes whose select bit is 1; with select 00 the memory is unchanged.
- R9: The data driver is never on while output enable is low. After every read, one cycle with all strobes high and the driver off comes before any further access.
- R10: req_ready is high only when a new request can be accepted, one request is accepted per ready cycle, and rsp_done is a single-cycle pulse that never coincides with req_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host has a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane select: bit 0 lower byte, bit 1 upper byte |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done after a read |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| sram_dq_out | output | 16 | Value to drive on the data pins |
| sram_dq_oe | output | 1 | Data pin driver enable, active high |
| sram_dq_in | input | 16 | Value sensed on the data pins |

## Verification
A sequencer that slips a state shows up at the strobe pins in the very cycle it goes wrong. A shortened or lengthened count changes the number of cycles with output enable or write enable low, and a missed turnaround leaves chip enable low one cycle too long. A corrupted lane register shows up as a wrong byte strobe during the access. If it is wrong in the capture path, it surfaces only at the done pulse as zeroed or stale read bytes. A write to the wrong lane is silent until the address is read back. The reference therefore compares every pin on every clock, and each write is followed by a read of the same word.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_ACCESS  = 3'd1,
    ST_RD_CAPTURE = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_HOLD    = 3'd5,
    ST_TURN       = 3'd6
  } ctrl_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic ub_n;
    logic lb_n;
    logic dq_oe;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                      ub_n: 1'b1, lb_n: 1'b1, dq_oe: 1'b0};

  // Strobe pattern that belongs to each state; lane bit 1 = upper byte.
  function automatic pin_ctl_t decode_pins(input ctrl_state_e s, input logic [1:0] lanes);
    pin_ctl_t p;
    p = PINS_QUIET;
    case (s)
      ST_RD_ACCESS: begin
        p.ce_n = 1'b0;
        p.oe_n = 1'b0;
        p.ub_n = ~lanes[1];
        p.lb_n = ~lanes[0];
      end
      ST_RD_CAPTURE: begin
        p.ce_n = 1'b0;
        p.ub_n = ~lanes[1];
        p.lb_n = ~lanes[0];
      end
      ST_WR_SETUP, ST_WR_HOLD: begin
        p.ce_n  = 1'b0;
        p.ub_n  = ~lanes[1];
        p.lb_n  = ~lanes[0];
        p.dq_oe = 1'b1;
      end
      ST_WR_PULSE: begin
        p.ce_n  = 1'b0;
        p.we_n  = 1'b0;
        p.ub_n  = ~lanes[1];
        p.lb_n  = ~lanes[0];
        p.dq_oe = 1'b1;
      end
      default: p = PINS_QUIET;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYCLES       = 2,
  parameter int WR_SETUP_CYCLES = 1,
  parameter int WR_PULSE_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  output ctrl_state_e state_d,
  output logic        accept,
  output logic        capture_en,
  output logic        ready_q,
  output logic        done_q
);

  localparam int MAX_A  = (RD_CYCLES > WR_SETUP_CYCLES) ? RD_CYCLES : WR_SETUP_CYCLES;
  localparam int MAX_C  = (MAX_A > WR_PULSE_CYCLES) ? MAX_A : WR_PULSE_CYCLES;
  localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);
  localparam logic [CNT_W-1:0] RD_LOAD    = CNT_W'(RD_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETUP_LOAD = CNT_W'(WR_SETUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(WR_PULSE_CYCLES - 1);

  ctrl_state_e      state_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign accept     = ready_q && req_valid;
  assign capture_en = (state_q == ST_RD_ACCESS) && cnt_zero;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          cnt_en = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SETUP;
            cnt_d   = SETUP_LOAD;
          end else begin
            state_d = ST_RD_ACCESS;
            cnt_d   = RD_LOAD;
          end
        end
      end
      ST_RD_ACCESS: begin
        if (cnt_zero) begin
          state_d = ST_RD_CAPTURE;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end
      ST_RD_CAPTURE: state_d = ST_TURN;
      ST_TURN:       state_d = ST_IDLE;
      ST_WR_SETUP: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          state_d = ST_WR_PULSE;
          cnt_d   = PULSE_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WR_PULSE: begin
        if (cnt_zero) begin
          state_d = ST_WR_HOLD;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end
      ST_WR_HOLD: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      ready_q <= (state_d == ST_IDLE);
      done_q  <= (state_d == ST_RD_CAPTURE) || (state_d == ST_WR_HOLD);
    end
  end

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  ctrl_state_e       state_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic [1:0]        lanes_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output pin_ctl_t          ctl_q
);

  logic [1:0] lanes_d;
  pin_ctl_t   ctl_d;

  assign lanes_d = accept ? req_be : lanes_q;
  assign ctl_d   = decode_pins(state_d, lanes_d);

  // Request fields load only on acceptance, which always falls in an idle
  // cycle with write enable high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lanes_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      lanes_q <= req_be;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= PINS_QUIET;
    end else begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic [1:0]        lanes_q,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  logic [LANE_W-1:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[g] <= '0;
      end else if (capture_en) begin
        lane_q[g] <= lanes_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
      end
    end
    assign rdata_q[g*LANE_W +: LANE_W] = lane_q[g];
  end

endmodule

// File: rtl/sram_bytelane_ctrl.sv
module sram_bytelane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W          = 18,
  parameter int DATA_W          = 16,
  parameter int RD_CYCLES       = 2,
  parameter int WR_SETUP_CYCLES = 1,
  parameter int WR_PULSE_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  ctrl_state_e state_d;
  logic        accept;
  logic        capture_en;
  logic [1:0]  lanes_q;
  pin_ctl_t    ctl_q;

  sram_seq_fsm #(
    .RD_CYCLES       (RD_CYCLES),
    .WR_SETUP_CYCLES (WR_SETUP_CYCLES),
    .WR_PULSE_CYCLES (WR_PULSE_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .state_d    (state_d),
    .accept     (accept),
    .capture_en (capture_en),
    .ready_q    (req_ready),
    .done_q     (rsp_done)
  );

  sram_pin_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .state_d   (state_d),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .lanes_q   (lanes_q),
    .addr_q    (sram_addr),
    .wdata_q   (sram_dq_out),
    .ctl_q     (ctl_q)
  );

  sram_rd_capture #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .lanes_q    (lanes_q),
    .dq_in      (sram_dq_in),
    .rdata_q    (rsp_rdata)
  );

  assign sram_ce_n  = ctl_q.ce_n;
  assign sram_we_n  = ctl_q.we_n;
  assign sram_oe_n  = ctl_q.oe_n;
  assign sram_ub_n  = ctl_q.ub_n;
  assign sram_lb_n  = ctl_q.lb_n;
  assign sram_dq_oe = ctl_q.dq_oe;

endmodule

// File: rtl/sram_bytelane_chk.sv
module sram_bytelane_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_ub_n,
  input logic              sram_lb_n,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (sram_ce_n && sram_we_n && sram_oe_n && sram_ub_n &&
                               sram_lb_n && !sram_dq_oe && !req_ready); // R1
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R2

  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_ce_n && sram_we_n)); // R3

  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_ce_n && sram_dq_oe)); // R6

  AST_WE_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out))); // R7

  AST_ADDR_MOVE_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sram_addr) |-> (sram_we_n && $past(sram_we_n))); // R7

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R10

  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready); // R10

endmodule

bind sram_bytelane_ctrl sram_bytelane_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .sram_addr   (sram_addr),
  .sram_ce_n   (sram_ce_n),
  .sram_we_n   (sram_we_n),
  .sram_oe_n   (sram_oe_n),
  .sram_ub_n   (sram_ub_n),
  .sram_lb_n   (sram_lb_n),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/tb_sram_bytelane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_bytelane_ctrl;

  localparam int AW = 18;
  localparam int DW = 16;
  localparam int RD = 3;
  localparam int SU = 2;
  localparam int PW = 3;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0]    req_be;
  logic          req_ready, rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
  logic [DW-1:0] sram_dq_out, sram_dq_in;
  logic          sram_dq_oe;

  sram_bytelane_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .RD_CYCLES(RD),
    .WR_SETUP_CYCLES(SU), .WR_PULSE_CYCLES(PW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit mem_arm = 1'b0;

  // ---------------- memory model on the pins ----------------
  logic [DW-1:0] pin_mem [int];
  logic [DW-1:0] exp_mem [int];

  function automatic logic [DW-1:0] seed_val(input int a);
    logic [AW-1:0] x;
    x = AW'(a);
    return x[15:0] ^ 16'h6C3A ^ {x[17:16], 14'h0};
  endfunction

  function automatic logic [DW-1:0] pin_get(input int a);
    if (pin_mem.exists(a)) return pin_mem[a];
    return seed_val(a);
  endfunction

  function automatic logic [DW-1:0] exp_get(input int a);
    if (exp_mem.exists(a)) return exp_mem[a];
    return seed_val(a);
  endfunction

  logic mem_drv;
  always @(sram_addr or sram_ce_n or sram_oe_n or sram_we_n or sram_ub_n or sram_lb_n) begin
    logic [DW-1:0] v;
    mem_drv = !sram_ce_n && !sram_oe_n && sram_we_n;
    v = pin_get(int'(sram_addr));
    sram_dq_in[7:0]  = (mem_drv && !sram_lb_n) ? v[7:0]  : 8'hEE;
    sram_dq_in[15:8] = (mem_drv && !sram_ub_n) ? v[15:8] : 8'hEE;
  end

  always @(posedge sram_we_n) begin
    if (mem_arm && rst_n && !sram_ce_n) begin
      logic [DW-1:0] v;
      v = pin_get(int'(sram_addr));
      if (!sram_dq_oe) begin
        errors++;
        $display("FAIL R5 write edge with bus undriven act=%0b exp=1", sram_dq_oe);
      end
      if (!sram_lb_n) v[7:0]  = sram_dq_out[7:0];
      if (!sram_ub_n) v[15:8] = sram_dq_out[15:8];
      pin_mem[int'(sram_addr)] = v;
    end
  end

  // ---------------- cycle reference ----------------
  // control vector: ready, ce_n, we_n, oe_n, ub_n, lb_n, dq_oe, done
  logic [7:0]    q_ctl [$];
  string         q_tag [$];
  logic [DW-1:0] q_rd  [$];
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_data = '0;

  function automatic logic [7:0] vec(input logic r, ce, we, oe, ub, lb, dq, dn);
    return {r, ce, we, oe, ub, lb, dq, dn};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [7:0] e, a;
    string t;
    @(negedge clk);
    a = {req_ready, sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, sram_dq_oe, rsp_done};
    if (!rst_n) begin
      e = vec(0, 1, 1, 1, 1, 1, 0, 0);
      t = "R1";
    end else if (q_ctl.size() > 0) begin
      e = q_ctl.pop_front();
      t = q_tag.pop_front();
    end else begin
      e = vec(1, 1, 1, 1, 1, 1, 0, 0);
      t = "R2";
    end
    chk(a == e, t, 32'(a), 32'(e));
    chk(sram_addr == cur_addr, "R7", 32'(sram_addr), 32'(cur_addr));
    if (e[1]) chk(sram_dq_out == cur_data, "R5", 32'(sram_dq_out), 32'(cur_data));
    if (t == "R4") begin
      logic [DW-1:0] er;
      er = q_rd.pop_front();
      chk(rsp_rdata == er, "R4", 32'(rsp_rdata), 32'(er));
    end
    if (sram_dq_oe && mem_drv) begin
      chk(1'b0, "R9", 32'(sram_dq_oe), 32'(0));
    end
  endtask

  task automatic push_read(input logic [AW-1:0] a, input logic [1:0] be);
    logic [DW-1:0] v;
    for (int i = 0; i < RD; i++) begin
      q_ctl.push_back(vec(0, 0, 1, 0, ~be[1], ~be[0], 0, 0)); q_tag.push_back("R3");
    end
    q_ctl.push_back(vec(0, 0, 1, 1, ~be[1], ~be[0], 0, 1)); q_tag.push_back("R4");
    q_ctl.push_back(vec(0, 1, 1, 1, 1, 1, 0, 0));           q_tag.push_back("R9");
    v = exp_get(int'(a));
    q_rd.push_back({be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00});
  endtask

  task automatic push_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    logic [DW-1:0] v;
    for (int i = 0; i < SU; i++) begin
      q_ctl.push_back(vec(0, 0, 1, 1, ~be[1], ~be[0], 1, 0)); q_tag.push_back("R5");
    end
    for (int i = 0; i < PW; i++) begin
      q_ctl.push_back(vec(0, 0, 0, 1, ~be[1], ~be[0], 1, 0)); q_tag.push_back("R6");
    end
    q_ctl.push_back(vec(0, 0, 1, 1, ~be[1], ~be[0], 1, 1)); q_tag.push_back("R5");
    v = exp_get(int'(a));
    if (be[0]) v[7:0]  = d[7:0];
    if (be[1]) v[15:8] = d[15:8];
    exp_mem[int'(a)] = v;
  endtask

  // Present a request; acceptance is decided now from the registered ready.
  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] be);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    forever begin
      if (req_ready) begin
        if (wr) push_write(a, d, be); else push_read(a, be);
        cur_addr = a;
        cur_data = d;
        tick();
        req_valid = 1'b0;
        break;
      end
      tick();
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b1; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    #1 rst_n = 1'b0;
    // R1: a write held during reset must not happen
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00005;
    req_wdata = 16'hFFFF; req_be = 2'b11;
    idle(4);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; req_valid = 1'b0;
    mem_arm = 1'b1;
    checks++;   // reset-release cycle still expected quiet, seen next tick
    idle(3);
    do_req(0, 18'h00005, 16'h0, 2'b11);          // R1 unchanged word
    idle(2);
    // R3 R4 R5 full-word write and read back
    do_req(1, 18'h00010, 16'h1234, 2'b11);
    idle(1);
    do_req(0, 18'h00010, 16'h0, 2'b11);
    // R8 upper-only, lower-only, none
    do_req(1, 18'h00010, 16'hABCD, 2'b10);
    do_req(0, 18'h00010, 16'h0, 2'b11);
    do_req(1, 18'h00010, 16'h5566, 2'b01);
    do_req(0, 18'h00010, 16'h0, 2'b11);
    do_req(1, 18'h00010, 16'h9999, 2'b00);
    do_req(0, 18'h00010, 16'h0, 2'b11);
    // R4 lane-masked reads
    do_req(0, 18'h00010, 16'h0, 2'b01);
    do_req(0, 18'h00010, 16'h0, 2'b10);
    do_req(0, 18'h00010, 16'h0, 2'b00);
    // R9 read then write back to back, R7 address extremes
    do_req(0, 18'h3FFFF, 16'h0, 2'b11);
    do_req(1, 18'h3FFFF, 16'hC3A5, 2'b11);
    do_req(0, 18'h3FFFF, 16'h0, 2'b11);
    do_req(1, 18'h00000, 16'h0F0F, 2'b11);
    do_req(0, 18'h00000, 16'h0, 2'b11);
    // R10 mixed stream over a small address window
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 60; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      do_req(lfsr[0], {14'h0, lfsr[4:1]}, lfsr[31:16], lfsr[6:5]);
      if (lfsr[7]) idle(int'(lfsr[9:8]));
    end
    for (int a = 0; a < 16; a++) do_req(0, AW'(a), 16'h0, 2'b11);
    idle(4);
    // R8 final memory contents
    foreach (exp_mem[k]) chk(pin_get(k) == exp_mem[k], "R8", 32'(pin_get(k)), 32'(exp_mem[k]));
    summary();
    $finish;
  end

endmodule